// File: doc/BRIEF.md
# Forty-Bit Accumulator ALU with Signed Barrel Shifter

This block is the arithmetic core of a fixed-point datapath. It holds a bank of four 40-bit accumulators and, for each issued operation, reads an A operand from one accumulator and a B operand from either another accumulator or a sign-extended 16-bit immediate. It applies one of ten operations (pass, add, subtract, three bitwise logic functions, rounding, saturation, and dual-lane 16-bit add or subtract), then passes the result through a barrel shifter controlled by a signed shift count. The shifted value is written into the selected destination accumulator on the next rising clock edge.

An operation is issued by raising `op_valid` for one cycle with the command fields valid. Any accumulator can be observed at any time through a combinational read port, so software-visible state is only what the bank holds. The dual-lane mode treats bits 15:0 and bits 31:16 as two independent 16-bit lanes, which suits packed complex or stereo samples held in one accumulator.

Top module: `acc40_alu_shift`

## Requirements
- R1: A synchronous active-high reset clears all four accumulators to zero.
- R2: Opcode 1 writes A+B and opcode 2 writes A-B, both modulo 2^40, into the destination accumulator at the clock edge that samples `op_valid` high; with `use_imm` low, B is the accumulator chosen by `srcb_sel`.
- R3: With `use_imm` high, B is `imm` sign-extended from bit 15 to 40 bits (0x8000 becomes 0xFF_FFFF_8000).
- R4: Opcodes 3, 4 and 5 write the bitwise AND, OR and XOR of A and B; opcode 0 writes B unchanged.
- R5: Opcode 6 (round) writes A plus 0x8000 with bits 15:0 then cleared, modulo 2^40; B is ignored.
- R6: Opcode 7 (saturate) writes A unchanged when bits 39:31 of A are all equal, else 0x00_7FFF_FFFF when bit 39 is 0 and 0xFF_8000_0000 when bit 39 is 1; B is ignored.
- R7: Opcodes 8 (dual add) and 9 (dual subtract) compute bits 15:0 as A[15:0]±B[15:0] and bits 31:16 as A[31:16]±B[31:16], each modulo 2^16 with no carry or borrow between lanes; bits 39:32 copy bit 31.
- R8: `shift_amt` is a 6-bit two's-complement count from -32 to +31 applied to the operation result before write-back: positive counts shift left filling zeros, negative counts shift right arithmetically filling with bit 39, zero passes the value through.
- R9: Only the accumulator chosen by `dst_sel` changes on an issued operation, and no accumulator changes in a cycle with `op_valid` low.
- R10: Opcodes 10 to 15 are reserved and write A (shifted per R8) to the destination.
- R11: `rd_data` shows the accumulator chosen by `rd_sel` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Issue an operation this cycle |
| op_code | input | 4 | Operation select (encodings in R2 to R10) |
| dst_sel | input | 2 | Destination accumulator index |
| srca_sel | input | 2 | A operand accumulator index |
| srcb_sel | input | 2 | B operand accumulator index |
| use_imm | input | 1 | Take B from the immediate instead of an accumulator |
| imm | input | 16 | Signed immediate operand |
| shift_amt | input | 6 | Signed shift count, -32 to +31 |
| rd_sel | input | 2 | Read port accumulator index |
| rd_data | output | 40 | Contents of the accumulator chosen by `rd_sel` |

## Verification
The properties assume the command fields are valid whenever `op_valid` is high and that `op_code` carries one of the sixteen defined values; the bench drives every field from a task at the falling edge so each issued command is stable across the sampling edge. The rounding and saturation properties only claim their result shape when the shift count is zero, and the bench's rounding and saturation scenarios issue with a zero count so the stimulus stays inside that premise. The lane-isolation property assumes nothing about operand values, so the dual-lane scenarios deliberately pick operands that overflow a lane.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    parameter int DATA_W  = 40;
    parameter int HALF_W  = 16;
    parameter int NUM_ACC = 4;
    parameter int SHAMT_W = 6;

    localparam int SEL_W  = $clog2(NUM_ACC);
    localparam int LANE_W = 2 * HALF_W;

    typedef enum logic [3:0] {
        OP_PASSB = 4'd0,
        OP_ADD   = 4'd1,
        OP_SUB   = 4'd2,
        OP_AND   = 4'd3,
        OP_OR    = 4'd4,
        OP_XOR   = 4'd5,
        OP_RND   = 4'd6,
        OP_SAT   = 4'd7,
        OP_ADD2  = 4'd8,
        OP_SUB2  = 4'd9
    } alu_op_e;

    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        logic              valid;
        logic [3:0]        code;
        logic [SEL_W-1:0]  dst;
        logic [SEL_W-1:0]  srca;
        logic [SEL_W-1:0]  srcb;
        logic              use_imm;
        logic [HALF_W-1:0] imm;
        logic [SHAMT_W-1:0] shamt;
    } alu_cmd_t;

    function automatic word_t widen_imm(input logic [HALF_W-1:0] v);
        return {{(DATA_W-HALF_W){v[HALF_W-1]}}, v};
    endfunction

    function automatic word_t round_half(input word_t v);
        word_t sum;
        sum = v + (word_t'(1) << (HALF_W-1));
        return {sum[DATA_W-1:HALF_W], {HALF_W{1'b0}}};
    endfunction

    function automatic word_t clamp_narrow(input word_t v);
        logic fits;
        fits = (&v[DATA_W-1:LANE_W-1]) | ~(|v[DATA_W-1:LANE_W-1]);
        if (fits)
            return v;
        else if (v[DATA_W-1])
            return {{(DATA_W-LANE_W+1){1'b1}}, {(LANE_W-1){1'b0}}};
        else
            return {{(DATA_W-LANE_W+1){1'b0}}, {(LANE_W-1){1'b1}}};
    endfunction

endpackage

// File: rtl/acc_bank.sv
module acc_bank #(
    parameter int DW   = acc_alu_pkg::DATA_W,
    parameter int NACC = acc_alu_pkg::NUM_ACC,
    localparam int SW  = $clog2(NACC)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [SW-1:0]            wr_sel,
    input  logic [DW-1:0]            wr_data,
    output logic [NACC-1:0][DW-1:0]  bank_q
);

    for (genvar k = 0; k < NACC; k++) begin : g_acc
        always_ff @(posedge clk) begin
            if (rst)
                bank_q[k] <= '0;
            else if (wr_en && (wr_sel == SW'(k)))
                bank_q[k] <= wr_data;
        end
    end

endmodule

// File: rtl/alu40_core.sv
module alu40_core
    import acc_alu_pkg::*;
#(
    parameter int DW = acc_alu_pkg::DATA_W,
    parameter int HW = acc_alu_pkg::HALF_W
) (
    input  logic [3:0]    op_code,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    output logic [DW-1:0] res
);

    localparam int LW = 2 * HW;

    logic [HW-1:0] lo_lane;
    logic [HW-1:0] hi_lane;
    logic          lane_sub;
    alu_op_e       op;

    assign op       = alu_op_e'(op_code);
    assign lane_sub = (op == OP_SUB2);

    // Two narrow adders: the lane boundary never sees a carry.
    always_comb begin
        if (lane_sub) begin
            lo_lane = opa[HW-1:0]  - opb[HW-1:0];
            hi_lane = opa[LW-1:HW] - opb[LW-1:HW];
        end else begin
            lo_lane = opa[HW-1:0]  + opb[HW-1:0];
            hi_lane = opa[LW-1:HW] + opb[LW-1:HW];
        end
    end

    always_comb begin
        case (op)
            OP_PASSB: res = opb;
            OP_ADD:   res = opa + opb;
            OP_SUB:   res = opa - opb;
            OP_AND:   res = opa & opb;
            OP_OR:    res = opa | opb;
            OP_XOR:   res = opa ^ opb;
            OP_RND:   res = round_half(opa);
            OP_SAT:   res = clamp_narrow(opa);
            OP_ADD2,
            OP_SUB2:  res = {{(DW-LW){hi_lane[HW-1]}}, hi_lane, lo_lane};
            default:  res = opa;
        endcase
    end

endmodule

// File: rtl/shift40.sv
module shift40 #(
    parameter int DW  = acc_alu_pkg::DATA_W,
    parameter int SHW = acc_alu_pkg::SHAMT_W
) (
    input  logic [DW-1:0]  din,
    input  logic [SHW-1:0] amt,
    output logic [DW-1:0]  dout
);

    logic           go_right;
    logic [SHW-1:0] mag;
    logic [DW-1:0]  stage [SHW+1];

    assign go_right = amt[SHW-1];
    assign mag      = go_right ? (~amt + SHW'(1)) : amt;
    assign stage[0] = din;

    // One stage per magnitude bit; direction is shared by all stages.
    for (genvar i = 0; i < SHW; i++) begin : g_stage
        localparam int STEP = 1 << i;
        always_comb begin
            if (!mag[i])
                stage[i+1] = stage[i];
            else if (go_right)
                stage[i+1] = DW'($signed(stage[i]) >>> STEP);
            else
                stage[i+1] = stage[i] << STEP;
        end
    end

    assign dout = stage[SHW];

endmodule

// File: rtl/acc40_alu_shift.sv
module acc40_alu_shift
    import acc_alu_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                op_valid,
    input  logic [3:0]          op_code,
    input  logic [SEL_W-1:0]    dst_sel,
    input  logic [SEL_W-1:0]    srca_sel,
    input  logic [SEL_W-1:0]    srcb_sel,
    input  logic                use_imm,
    input  logic [HALF_W-1:0]   imm,
    input  logic [SHAMT_W-1:0]  shift_amt,
    input  logic [SEL_W-1:0]    rd_sel,
    output logic [DATA_W-1:0]   rd_data
);

    alu_cmd_t                      cmd;
    logic [NUM_ACC-1:0][DATA_W-1:0] bank_q;
    word_t                         opa;
    word_t                         opb;
    word_t                         alu_y;
    word_t                         wb_data;

    assign cmd = '{valid:   op_valid,
                   code:    op_code,
                   dst:     dst_sel,
                   srca:    srca_sel,
                   srcb:    srcb_sel,
                   use_imm: use_imm,
                   imm:     imm,
                   shamt:   shift_amt};

    assign opa = bank_q[cmd.srca];
    assign opb = cmd.use_imm ? widen_imm(cmd.imm) : bank_q[cmd.srcb];

    alu40_core #(.DW(DATA_W), .HW(HALF_W)) u_alu (
        .op_code (cmd.code),
        .opa     (opa),
        .opb     (opb),
        .res     (alu_y)
    );

    shift40 #(.DW(DATA_W), .SHW(SHAMT_W)) u_shift (
        .din  (alu_y),
        .amt  (cmd.shamt),
        .dout (wb_data)
    );

    acc_bank #(.DW(DATA_W), .NACC(NUM_ACC)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cmd.valid),
        .wr_sel  (cmd.dst),
        .wr_data (wb_data),
        .bank_q  (bank_q)
    );

    assign rd_data = bank_q[rd_sel];

endmodule

// File: rtl/acc40_alu_chk.sv
module acc40_alu_chk
    import acc_alu_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        op_valid,
    input  logic [3:0]                  op_code,
    input  logic [SEL_W-1:0]            dst_sel,
    input  logic [SHAMT_W-1:0]          shift_amt,
    input  logic [DATA_W-1:0]           wb_data,
    input  logic [NUM_ACC-1:0][DATA_W-1:0] bank_q
);

    localparam int LW = 2 * HALF_W;

    // R1: the cycle after reset every accumulator reads zero
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (bank_q == '0));

    // R9: idle cycles leave the whole bank untouched
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> $stable(bank_q));

    // R9: accumulators other than the destination keep their value
    for (genvar k = 0; k < NUM_ACC; k++) begin : g_iso
        assert_other_hold_R9: assert property (@(posedge clk) disable iff (rst)
            (op_valid && dst_sel != SEL_W'(k)) |=> $stable(bank_q[k]));
    end

    // R9: the destination receives the shifter output
    assert_dst_written_R9: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> (bank_q[$past(dst_sel)] == $past(wb_data)));

    // R5: an unshifted rounded value has a clear low half
    assert_round_low_R5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_RND && shift_amt == '0)
        |-> (wb_data[HALF_W-1:0] == '0));

    // R6: an unshifted saturated value fits the narrow signed range
    assert_sat_fits_R6: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_SAT && shift_amt == '0)
        |-> ((&wb_data[DATA_W-1:LW-1]) || !(|wb_data[DATA_W-1:LW-1])));

    // R7: dual-lane results carry the upper lane sign into the guard bits
    assert_lane_guard_R7: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_code == OP_ADD2 || op_code == OP_SUB2) && shift_amt == '0)
        |-> ((&wb_data[DATA_W-1:LW-1]) || !(|wb_data[DATA_W-1:LW-1])));

endmodule

bind acc40_alu_shift acc40_alu_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .dst_sel   (dst_sel),
    .shift_amt (shift_amt),
    .wb_data   (wb_data),
    .bank_q    (bank_q)
);

// File: tb/sim_acc40_alu_shift.sv
`timescale 1ns/1ps
module sim_acc40_alu_shift;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [3:0]  op_code;
    logic [1:0]  dst_sel, srca_sel, srcb_sel, rd_sel;
    logic        use_imm;
    logic [15:0] imm;
    logic [5:0]  shift_amt;
    logic [39:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    acc40_alu_shift u0 (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .dst_sel(dst_sel), .srca_sel(srca_sel), .srcb_sel(srcb_sel),
        .use_imm(use_imm), .imm(imm), .shift_amt(shift_amt),
        .rd_sel(rd_sel), .rd_data(rd_data)
    );

    task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%010h expected=%010h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] code, input logic [1:0] dst,
                         input logic [1:0] sa, input logic [1:0] sb,
                         input logic ui, input logic [15:0] iv, input logic [5:0] sh);
        @(negedge clk);
        op_valid = 1'b1; op_code = code; dst_sel = dst; srca_sel = sa;
        srcb_sel = sb; use_imm = ui; imm = iv; shift_amt = sh;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic peek(input logic [1:0] sel, output logic [39:0] v);
        rd_sel = sel;
        #0.5;
        v = rd_data;
    endtask

    // Builds a 40-bit value through byte-wide OR and left shift by 8.
    task automatic load(input logic [1:0] dst, input logic [39:0] v);
        issue(4'd0, dst, dst, dst, 1'b1, 16'h0000, 6'd0);
        for (int i = 4; i >= 1; i--)
            issue(4'd4, dst, dst, dst, 1'b1, {8'h00, v[i*8 +: 8]}, 6'd8);
        issue(4'd4, dst, dst, dst, 1'b1, {8'h00, v[7:0]}, 6'd0);
    endtask

    task automatic t_reset;
        logic [39:0] v;
        for (int k = 0; k < 4; k++) begin
            peek(2'(k), v);
            check("R1 reset clears accumulator", v, 40'h0);
        end
        peek(2'd2, v);
        check("R11 read port selects index", v, 40'h0);
    endtask

    task automatic t_add_sub;
        logic [39:0] v;
        load(2'd0, 40'h12_3456_789A);
        load(2'd1, 40'h00_0000_0001);
        peek(2'd0, v);
        check("R11 loaded value visible", v, 40'h12_3456_789A);
        issue(4'd1, 2'd2, 2'd0, 2'd1, 1'b0, 16'h0, 6'd0);
        peek(2'd2, v);
        check("R2 add", v, 40'h12_3456_789B);
        load(2'd3, 40'h0);
        issue(4'd2, 2'd2, 2'd3, 2'd1, 1'b0, 16'h0, 6'd0);
        peek(2'd2, v);
        check("R2 subtract wraps at 40 bits", v, 40'hFF_FFFF_FFFF);
        load(2'd3, 40'hFF_FFFF_FFFF);
        issue(4'd1, 2'd2, 2'd3, 2'd1, 1'b0, 16'h0, 6'd0);
        peek(2'd2, v);
        check("R2 add carries out of bit 39", v, 40'h0);
    endtask

    task automatic t_imm;
        logic [39:0] v;
        issue(4'd1, 2'd2, 2'd1, 2'd0, 1'b1, 16'h8000, 6'd0);
        peek(2'd2, v);
        check("R3 negative immediate sign-extended", v, 40'hFF_FFFF_8001);
        issue(4'd1, 2'd2, 2'd1, 2'd0, 1'b1, 16'h7FFF, 6'd0);
        peek(2'd2, v);
        check("R3 positive immediate", v, 40'h00_0000_8000);
    endtask

    task automatic t_logic;
        logic [39:0] v;
        load(2'd1, 40'hF0_0FF0_0FF0);
        issue(4'd3, 2'd2, 2'd0, 2'd1, 1'b0, 16'h0, 6'd0);
        peek(2'd2, v);
        check("R4 and", v, 40'h12_3456_789A & 40'hF0_0FF0_0FF0);
        issue(4'd4, 2'd2, 2'd0, 2'd1, 1'b0, 16'h0, 6'd0);
        peek(2'd2, v);
        check("R4 or", v, 40'h12_3456_789A | 40'hF0_0FF0_0FF0);
        issue(4'd5, 2'd2, 2'd0, 2'd1, 1'b0, 16'h0, 6'd0);
        peek(2'd2, v);
        check("R4 xor", v, 40'h12_3456_789A ^ 40'hF0_0FF0_0FF0);
        issue(4'd0, 2'd2, 2'd0, 2'd1, 1'b0, 16'h0, 6'd0);
        peek(2'd2, v);
        check("R4 pass B", v, 40'hF0_0FF0_0FF0);
    endtask

    task automatic t_round;
        logic [39:0] v;
        load(2'd1, 40'h00_1234_8000);
        issue(4'd6, 2'd2, 2'd1, 2'd0, 1'b1, 16'h1234, 6'd0);
        peek(2'd2, v);
        check("R5 round up at half", v, 40'h00_1235_0000);
        load(2'd1, 40'h00_1234_7FFF);
        issue(4'd6, 2'd2, 2'd1, 2'd0, 1'b0, 16'h0, 6'd0);
        peek(2'd2, v);
        check("R5 round down below half", v, 40'h00_1234_0000);
        load(2'd1, 40'hFF_FFFF_8000);
        issue(4'd6, 2'd2, 2'd1, 2'd0, 1'b0, 16'h0, 6'd0);
        peek(2'd2, v);
        check("R5 round wraps to zero", v, 40'h0);
    endtask

    task automatic t_sat;
        logic [39:0] v;
        load(2'd1, 40'h00_8000_0000);
        issue(4'd7, 2'd2, 2'd1, 2'd0, 1'b1, 16'hFFFF, 6'd0);
        peek(2'd2, v);
        check("R6 positive clamp", v, 40'h00_7FFF_FFFF);
        load(2'd1, 40'hFF_0000_0000);
        issue(4'd7, 2'd2, 2'd1, 2'd0, 1'b0, 16'h0, 6'd0);
        peek(2'd2, v);
        check("R6 negative clamp", v, 40'hFF_8000_0000);
        load(2'd1, 40'hFF_8000_0000);
        issue(4'd7, 2'd2, 2'd1, 2'd0, 1'b0, 16'h0, 6'd0);
        peek(2'd2, v);
        check("R6 in-range negative unchanged", v, 40'hFF_8000_0000);
        load(2'd1, 40'h00_7FFF_FFFF);
        issue(4'd7, 2'd2, 2'd1, 2'd0, 1'b0, 16'h0, 6'd0);
        peek(2'd2, v);
        check("R6 in-range positive unchanged", v, 40'h00_7FFF_FFFF);
    endtask

    task automatic t_split;
        logic [39:0] v;
        load(2'd0, 40'h00_0001_FFFF);
        load(2'd1, 40'h00_0001_0001);
        issue(4'd8, 2'd2, 2'd0, 2'd1, 1'b0, 16'h0, 6'd0);
        peek(2'd2, v);
        check("R7 dual add blocks lane carry", v, 40'h00_0002_0000);
        load(2'd0, 40'h00_7FFF_0000);
        load(2'd1, 40'h00_0001_0000);
        issue(4'd8, 2'd2, 2'd0, 2'd1, 1'b0, 16'h0, 6'd0);
        peek(2'd2, v);
        check("R7 dual add upper lane sign to guard", v, 40'hFF_8000_0000);
        load(2'd0, 40'h00_0005_0000);
        load(2'd1, 40'h00_0000_0001);
        issue(4'd9, 2'd2, 2'd0, 2'd1, 1'b0, 16'h0, 6'd0);
        peek(2'd2, v);
        check("R7 dual subtract blocks lane borrow", v, 40'h00_0005_FFFF);
    endtask

    task automatic t_shift;
        logic [39:0] v;
        logic [39:0] src;
        src = 40'h12_3456_789A;
        load(2'd0, src);
        issue(4'd0, 2'd2, 2'd1, 2'd0, 1'b0, 16'h0, 6'd31);
        peek(2'd2, v);
        check("R8 left 31 zero fill", v, src << 31);
        issue(4'd0, 2'd2, 2'd1, 2'd0, 1'b0, 16'h0, 6'h3C);
        peek(2'd2, v);
        check("R8 right 4 positive", v, 40'h01_2345_6789);
        issue(4'd0, 2'd2, 2'd1, 2'd0, 1'b1, 16'h8000, 6'h20);
        peek(2'd2, v);
        check("R8 right 32 sign fill", v, 40'hFF_FFFF_FFFF);
        issue(4'd0, 2'd2, 2'd1, 2'd0, 1'b0, 16'h0, 6'h20);
        peek(2'd2, v);
        check("R8 right 32 positive", v, 40'h00_0000_0012);
        load(2'd1, 40'hFF_8000_0000);
        issue(4'd0, 2'd2, 2'd0, 2'd1, 1'b0, 16'h0, 6'h3C);
        peek(2'd2, v);
        check("R8 right 4 negative", v, 40'hFF_F800_0000);
    endtask

    task automatic t_isolation;
        logic [39:0] v;
        load(2'd0, 40'h11_1111_1111);
        load(2'd1, 40'h22_2222_2222);
        load(2'd2, 40'h33_3333_3333);
        load(2'd3, 40'h44_4444_4444);
        issue(4'd1, 2'd2, 2'd0, 2'd1, 1'b0, 16'h0, 6'd0);
        peek(2'd0, v); check("R9 acc0 untouched", v, 40'h11_1111_1111);
        peek(2'd1, v); check("R9 acc1 untouched", v, 40'h22_2222_2222);
        peek(2'd3, v); check("R9 acc3 untouched", v, 40'h44_4444_4444);
        peek(2'd2, v); check("R9 destination written", v, 40'h33_3333_3333);
        @(negedge clk);
        op_valid = 1'b0; op_code = 4'd1; dst_sel = 2'd3; srca_sel = 2'd0;
        srcb_sel = 2'd1; use_imm = 1'b0; shift_amt = 6'd4;
        @(negedge clk);
        peek(2'd3, v); check("R9 idle cycle ignored", v, 40'h44_4444_4444);
    endtask

    task automatic t_reserved;
        logic [39:0] v;
        issue(4'd15, 2'd3, 2'd0, 2'd1, 1'b1, 16'h7777, 6'd0);
        peek(2'd3, v);
        check("R10 reserved passes A", v, 40'h11_1111_1111);
        issue(4'd10, 2'd3, 2'd1, 2'd0, 1'b0, 16'h0, 6'd4);
        peek(2'd3, v);
        check("R10 reserved A shifted", v, 40'h22_2222_2220);
    endtask

    initial begin
        rst = 1'b1; op_valid = 1'b0; op_code = '0; dst_sel = '0; srca_sel = '0;
        srcb_sel = '0; use_imm = 1'b0; imm = '0; shift_amt = '0; rd_sel = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_add_sub();
        t_imm();
        t_logic();
        t_round();
        t_sat();
        t_split();
        t_shift();
        t_isolation();
        t_reserved();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule